// File: doc/BRIEF.md
# External SYNC PWM Clock Synchronizer

This block produces the cycle-start strobe of a PWM switching period counter and, when asked to, locks that counter to an external SYNC square wave. The counter runs freely at the programmed period until synchronization is enabled and soft start is over. From then on the block counts clock cycles between selected SYNC rising edges. With a divide ratio of N (1 to 4), every N-th SYNC rising edge is selected. Each measured interval is checked against a capture window of one eighth of the programmed period on either side. Seven accepted intervals in a row are averaged into the active period.

After the averaging stage, the next accepted edge starts a programmable delay. When that delay expires, the counter restarts and lock is declared. While locked, every selected SYNC edge ends the running switching cycle after the same fixed latency, so the switching frequency follows SYNC pulse by pulse. Any of these events sends the block back to the programmed period and restarts acquisition: a measurement outside the window, a missing edge, soft start, or a cleared enable.

The SYNC pin is asynchronous to the block clock. It passes through a two-flop synchronizer and a rising-edge detector before it is used anywhere.

Top module: `syncpwm_top`

## Requirements
- R1: SYNC is resynchronized by two flops before use. When locked with a delay setting of d clocks, `cycleStart` is registered high at the (d+2)-th rising clock edge after the first edge that samples a selected SYNC rising edge high.
- R2: `divSel` selects every N-th SYNC rising edge, with N = `divSel`+1 (0 gives 1, 3 gives 4). The interval between selected edges is accepted only if it lies within [P - floor(P/8), P + floor(P/8)] clock cycles, where P is `periodCfg`.
- R3: After seven consecutive accepted intervals, `activePeriod` equals the floor of their mean. A rejected interval restarts the count of seven.
- R4: After the averaging stage, the next accepted selected edge starts the phase delay. When the delay expires, the counter restarts and `locked` rises, in the same cycle as a `cycleStart` pulse.
- R5: While locked, consecutive `cycleStart` pulses are spaced exactly by the interval between selected SYNC edges (N times the SYNC period).
- R6: If no selected edge arrives within P + floor(P/8) clocks of the previous one, `locked` goes low, `activePeriod` returns to P and the counter runs freely at P.
- R7: A selected edge whose interval lies outside the window clears `locked` and restarts acquisition from the averaging stage.
- R8: While `softStart` is high, SYNC is ignored: `locked` stays low, `activePeriod` equals P and `cycleStart` repeats every P clocks.
- R9: While `syncEn` is low, SYNC is ignored in the same way as in R8.
- R10: After reset, `locked` is 0, `activePeriod` equals P and `cycleStart` is 0. When running freely, `cycleStart` is a one-cycle pulse every `activePeriod` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| syncIn | input | 1 | External SYNC pin, asynchronous |
| syncEn | input | 1 | Enables synchronization to SYNC |
| softStart | input | 1 | High during soft start; SYNC ignored |
| periodCfg | input | CNT_W | Programmed switching period in clocks |
| phaseDly | input | CNT_W | Delay from selected SYNC edge to cycle start, in clocks |
| divSel | input | 2 | Divide ratio select: N = divSel+1 |
| cycleStart | output | 1 | One-cycle pulse at the start of each switching cycle |
| locked | output | 1 | High when phase-locked to SYNC |
| activePeriod | output | CNT_W | Period in force: averaged SYNC period or periodCfg |

## Verification
The hardest situation to reach is the exact edge of the capture window. An interval of P + floor(P/8) must be accepted and one clock longer rejected. The rejected case also sits right on the loss-detection threshold, so the two paths compete. The bench drives a SYNC generator whose period is set in whole clocks, with P = 100. It runs the whole acquisition at 112 and at 113 clocks and checks lock, and on the locked run checks the fixed latency with zero delay. The divided modes are reached by picking SYNC periods whose N-fold multiple falls inside the window.

// File: rtl/syncpwm_pkg.sv
package syncpwm_pkg;

  // number of accepted intervals averaged during frequency capture
  localparam int ACC_N = 7;

  typedef enum logic [2:0] {
    ST_FREE,   // unsynchronized, programmed period
    ST_ARM,    // waiting for an anchor edge
    ST_FREQ,   // accumulating intervals
    ST_PHASE,  // average known, aligning phase
    ST_LOCK    // pulse-by-pulse termination
  } syncState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic track;       // measurement logic running
    logic clearAcc;    // clear accumulator and pending delay
    logic accumulate;  // add current interval
    logic captureAvg;  // latch mean including current interval
    logic armDelay;    // start phase delay
    logic restartCnt;  // force counter restart
    logic useAvg;      // averaged period in force
    logic lockWrap;    // relaxed wrap limit while locked
  } ctrlStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic evt;         // selected SYNC edge this cycle
    logic inRange;     // current interval inside capture window
    logic lost;        // no edge within window upper bound
    logic delayDone;   // phase delay expires this cycle
  } dpStatus_t;

endpackage

// File: rtl/syncpwm_ctrl.sv
module syncpwm_ctrl
  import syncpwm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        syncEn,
  input  logic        softStart,
  input  dpStatus_t   stat,
  output ctrlStrobe_t ctrl,
  output logic        locked
);

  localparam int ACC_W = $clog2(ACC_N + 1);

  syncState_t state, stateNext;
  logic [ACC_W-1:0] accCnt;
  logic active;

  assign active = syncEn & ~softStart;

  always_comb begin
    stateNext       = state;
    ctrl            = '0;
    ctrl.track      = active;
    ctrl.useAvg     = (state == ST_PHASE) || (state == ST_LOCK);
    ctrl.lockWrap   = (state == ST_LOCK);
    if (!active) begin
      stateNext     = ST_FREE;
      ctrl.clearAcc = 1'b1;
      ctrl.useAvg   = 1'b0;
      ctrl.lockWrap = 1'b0;
    end else begin
      unique case (state)
        ST_FREE: begin
          stateNext     = ST_ARM;
          ctrl.clearAcc = 1'b1;
        end
        ST_ARM: begin
          if (stat.evt) begin
            stateNext     = ST_FREQ;
            ctrl.clearAcc = 1'b1;
          end
        end
        ST_FREQ: begin
          if (stat.evt) begin
            if (stat.inRange) begin
              ctrl.accumulate = 1'b1;
              if (accCnt == ACC_W'(ACC_N - 1)) begin
                ctrl.captureAvg = 1'b1;
                stateNext       = ST_PHASE;
              end
            end else begin
              ctrl.clearAcc = 1'b1;
            end
          end else if (stat.lost) begin
            stateNext     = ST_ARM;
            ctrl.clearAcc = 1'b1;
          end
        end
        ST_PHASE, ST_LOCK: begin
          if (stat.evt && !stat.inRange) begin
            stateNext     = ST_FREQ;
            ctrl.clearAcc = 1'b1;
          end else if (!stat.evt && stat.lost) begin
            stateNext     = ST_ARM;
            ctrl.clearAcc = 1'b1;
          end else begin
            if (stat.evt) ctrl.armDelay = 1'b1;
            if (stat.delayDone) begin
              ctrl.restartCnt = 1'b1;
              stateNext       = ST_LOCK;
            end
          end
        end
        default: begin
          stateNext     = ST_FREE;
          ctrl.clearAcc = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_FREE;
      accCnt <= '0;
    end else begin
      state <= stateNext;
      if (ctrl.clearAcc || ctrl.captureAvg) accCnt <= '0;
      else if (ctrl.accumulate)             accCnt <= accCnt + 1'b1;
    end
  end

  assign locked = (state == ST_LOCK);

endmodule

// File: rtl/syncpwm_datapath.sv
module syncpwm_datapath
  import syncpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncIn,
  input  logic [CNT_W-1:0] periodCfg,
  input  logic [CNT_W-1:0] phaseDly,
  input  logic [1:0]       divSel,
  input  ctrlStrobe_t      ctrl,
  output dpStatus_t        stat,
  output logic             cycleStart,
  output logic [CNT_W-1:0] activePeriod
);

  localparam int EXT_W = CNT_W + 1;
  localparam int SUM_W = CNT_W + $clog2(ACC_N + 1) + 1;

  // ---------------- SYNC resynchronization and edge detect
  logic syncMeta, syncStable, syncLast, syncRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncMeta   <= 1'b0;
      syncStable <= 1'b0;
      syncLast   <= 1'b0;
    end else begin
      syncMeta   <= syncIn;
      syncStable <= syncMeta;
      syncLast   <= syncStable;
    end
  end

  assign syncRise = syncStable & ~syncLast;

  // ---------------- edge divider
  logic [1:0] divCnt;
  logic       evt;

  assign evt = ctrl.track & syncRise & (divCnt == divSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              divCnt <= '0;
    else if (!ctrl.track)   divCnt <= '0;
    else if (syncRise)      divCnt <= (divCnt == divSel) ? 2'd0 : divCnt + 2'd1;
  end

  // ---------------- interval measurement
  logic [CNT_W-1:0] measCnt;
  logic [EXT_W-1:0] measPeriod, winLo, winHi, eighth;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       measCnt <= '0;
    else if (!ctrl.track || evt)     measCnt <= '0;
    else if (measCnt != '1)          measCnt <= measCnt + 1'b1;
  end

  assign measPeriod = EXT_W'(measCnt) + EXT_W'(1);
  assign eighth     = EXT_W'(periodCfg >> 3);
  assign winLo      = EXT_W'(periodCfg) - eighth;
  assign winHi      = EXT_W'(periodCfg) + eighth;

  assign stat.evt     = evt;
  assign stat.inRange = (measPeriod >= winLo) && (measPeriod <= winHi);
  assign stat.lost    = (EXT_W'(measCnt) >= winHi);

  // ---------------- averaging
  logic [SUM_W-1:0] accSum, accTotal, accMean;
  logic [CNT_W-1:0] avgReg;

  assign accTotal = accSum + SUM_W'(measPeriod);
  assign accMean  = accTotal / SUM_W'(ACC_N);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accSum <= '0;
      avgReg <= '0;
    end else begin
      if (ctrl.clearAcc || ctrl.captureAvg) accSum <= '0;
      else if (ctrl.accumulate)             accSum <= accTotal;
      if (ctrl.captureAvg)                  avgReg <= accMean[CNT_W-1:0];
    end
  end

  // ---------------- phase delay
  logic [CNT_W-1:0] dlyCnt;
  logic             dlyBusy;

  assign stat.delayDone = (ctrl.armDelay && (phaseDly == '0)) ||
                          (dlyBusy && (dlyCnt == CNT_W'(1)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlyCnt  <= '0;
      dlyBusy <= 1'b0;
    end else if (ctrl.clearAcc) begin
      dlyBusy <= 1'b0;
    end else if (ctrl.armDelay && (phaseDly != '0)) begin
      dlyCnt  <= phaseDly;
      dlyBusy <= 1'b1;
    end else if (dlyBusy) begin
      if (dlyCnt == CNT_W'(1)) dlyBusy <= 1'b0;
      else                     dlyCnt  <= dlyCnt - 1'b1;
    end
  end

  // ---------------- switching period counter
  logic [EXT_W-1:0] perCnt, wrapLimit;

  assign activePeriod = ctrl.useAvg ? avgReg : periodCfg;
  assign wrapLimit    = ctrl.lockWrap ? (EXT_W'(periodCfg) << 1) : EXT_W'(activePeriod);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perCnt     <= '0;
      cycleStart <= 1'b0;
    end else if (ctrl.restartCnt || (perCnt + EXT_W'(1) >= wrapLimit)) begin
      perCnt     <= '0;
      cycleStart <= 1'b1;
    end else begin
      perCnt     <= perCnt + 1'b1;
      cycleStart <= 1'b0;
    end
  end

endmodule

// File: rtl/syncpwm_top.sv
module syncpwm_top
  import syncpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncIn,
  input  logic             syncEn,
  input  logic             softStart,
  input  logic [CNT_W-1:0] periodCfg,
  input  logic [CNT_W-1:0] phaseDly,
  input  logic [1:0]       divSel,
  output logic             cycleStart,
  output logic             locked,
  output logic [CNT_W-1:0] activePeriod
);

  ctrlStrobe_t ctrl;
  dpStatus_t   stat;

  syncpwm_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .syncEn    (syncEn),
    .softStart (softStart),
    .stat      (stat),
    .ctrl      (ctrl),
    .locked    (locked)
  );

  syncpwm_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .syncIn       (syncIn),
    .periodCfg    (periodCfg),
    .phaseDly     (phaseDly),
    .divSel       (divSel),
    .ctrl         (ctrl),
    .stat         (stat),
    .cycleStart   (cycleStart),
    .activePeriod (activePeriod)
  );

endmodule

// File: rtl/syncpwm_checker.sv
module syncpwm_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             syncEn,
  input logic             softStart,
  input logic [CNT_W-1:0] periodCfg,
  input logic             cycleStart,
  input logic             locked,
  input logic [CNT_W-1:0] activePeriod
);

  logic [CNT_W:0] chkLo, chkHi;
  assign chkLo = (CNT_W+1)'(periodCfg) - (CNT_W+1)'(periodCfg >> 3);
  assign chkHi = (CNT_W+1)'(periodCfg) + (CNT_W+1)'(periodCfg >> 3);

  AST_SOFTSTART_NO_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    softStart |=> !locked); // R8

  AST_DISABLED_NO_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    !syncEn |=> !locked); // R9

  AST_IDLE_PROGRAMMED_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    (!syncEn || softStart) |=> (activePeriod == $past(periodCfg))); // R9

  AST_LOCK_ENTRY_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> cycleStart); // R4

  AST_LOCK_PERIOD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (locked && $stable(periodCfg)) |->
      (((CNT_W+1)'(activePeriod) >= chkLo) && ((CNT_W+1)'(activePeriod) <= chkHi))); // R3

endmodule

bind syncpwm_top syncpwm_checker #(.CNT_W(CNT_W)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .syncEn       (syncEn),
  .softStart    (softStart),
  .periodCfg    (periodCfg),
  .cycleStart   (cycleStart),
  .locked       (locked),
  .activePeriod (activePeriod)
);

// File: tb/syncpwm_top_tb_top.sv
`timescale 1ns/1ps
module syncpwm_top_tb_top;

  localparam int CNT_W = 16;
  localparam int PCFG  = 100;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             syncIn = 1'b0;
  logic             syncEn = 1'b0;
  logic             softStart = 1'b0;
  logic [CNT_W-1:0] periodCfg = CNT_W'(PCFG);
  logic [CNT_W-1:0] phaseDly = '0;
  logic [1:0]       divSel = 2'd0;
  logic             cycleStart;
  logic             locked;
  logic [CNT_W-1:0] activePeriod;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int syncPer = 0;
  int syncRiseCyc = 0;
  int lastStart = 0;
  int prevStart = 0;
  int startCount = 0;
  int lastGapSync = 0;

  always #10 clk = ~clk;  // 50 MHz

  syncpwm_top #(.CNT_W(CNT_W)) dut_i (
    .clk          (clk),
    .rstN         (rstN),
    .syncIn       (syncIn),
    .syncEn       (syncEn),
    .softStart    (softStart),
    .periodCfg    (periodCfg),
    .phaseDly     (phaseDly),
    .divSel       (divSel),
    .cycleStart   (cycleStart),
    .locked       (locked),
    .activePeriod (activePeriod)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // SYNC generator: period syncPer clocks, high for two clocks, 0 = idle
  initial begin
    forever begin
      if (syncPer == 0) begin
        @(negedge clk);
        syncIn = 1'b0;
      end else begin
        syncIn = 1'b1;
        syncRiseCyc = cyc;
        repeat (2) @(negedge clk);
        syncIn = 1'b0;
        repeat (syncPer - 2) @(negedge clk);
      end
    end
  end

  // monitor of cycleStart pulses, sampled away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (cycleStart === 1'b1) begin
        prevStart   = lastStart;
        lastStart   = cyc;
        lastGapSync = cyc - syncRiseCyc;
        startCount++;
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic startGap(output int gap);
    int n0;
    n0 = startCount;
    while (startCount < n0 + 2) @(negedge clk);
    gap = lastStart - prevStart;
  endtask

  task automatic quiesce();
    syncPer = 0;
    syncEn  = 1'b0;
    softStart = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic runSync(input int per, input int div, input int dly);
    quiesce();
    divSel   = 2'(div);
    phaseDly = CNT_W'(dly);
    syncPer  = per;
    syncEn   = 1'b1;
    repeat (12 * per * (div + 1) + 200) @(negedge clk);
  endtask

  task automatic testReset();
    check("R10", "reset locked", int'(locked), 0);
    check("R10", "reset activePeriod", int'(activePeriod), PCFG);
    check("R10", "reset cycleStart", int'(cycleStart), 0);
  endtask

  task automatic testFreeRun();
    int gap;
    quiesce();
    repeat (3) startGap(gap);
    check("R10", "free-run spacing", gap, PCFG);
  endtask

  task automatic testSoftStart();
    int gap;
    quiesce();
    softStart = 1'b1;
    syncEn    = 1'b1;
    syncPer   = 105;
    repeat (1500) @(negedge clk);
    check("R8", "soft start locked", int'(locked), 0);
    check("R8", "soft start activePeriod", int'(activePeriod), PCFG);
    startGap(gap);
    check("R8", "soft start spacing", gap, PCFG);
  endtask

  task automatic testDisabled();
    int gap;
    quiesce();
    syncPer = 105;
    repeat (1500) @(negedge clk);
    check("R9", "disabled locked", int'(locked), 0);
    check("R9", "disabled activePeriod", int'(activePeriod), PCFG);
    startGap(gap);
    check("R9", "disabled spacing", gap, PCFG);
  endtask

  task automatic testLockDiv1();
    int gap;
    runSync(105, 0, 5);
    check("R4", "div1 locked", int'(locked), 1);
    check("R3", "div1 averaged period", int'(activePeriod), 105);
    startGap(gap);
    check("R5", "div1 locked spacing", gap, 105);
    check("R1", "div1 latency with delay 5", lastGapSync, 8);
  endtask

  task automatic testLockDivN(input int div, input int per, input string req);
    int gap;
    runSync(per, div, 4);
    check(req, "divided locked", int'(locked), 1);
    check("R3", "divided averaged period", int'(activePeriod), per * (div + 1));
    startGap(gap);
    check("R5", "divided locked spacing", gap, per * (div + 1));
  endtask

  task automatic testWindowEdge();
    int gap;
    runSync(112, 0, 0);
    check("R2", "window edge 112 locked", int'(locked), 1);
    check("R2", "window edge 112 period", int'(activePeriod), 112);
    startGap(gap);
    check("R1", "latency with zero delay", lastGapSync, 3);
    runSync(113, 0, 0);
    check("R2", "window edge 113 locked", int'(locked), 0);
    check("R2", "window edge 113 period", int'(activePeriod), PCFG);
    runSync(87, 0, 0);
    check("R2", "window edge 87 locked", int'(locked), 0);
    runSync(88, 0, 0);
    check("R2", "window edge 88 locked", int'(locked), 1);
  endtask

  task automatic testJump();
    runSync(105, 0, 2);
    check("R7", "before jump locked", int'(locked), 1);
    syncPer = 80;
    repeat (400) @(negedge clk);
    check("R7", "after jump locked", int'(locked), 0);
    check("R7", "after jump activePeriod", int'(activePeriod), PCFG);
  endtask

  task automatic testLoss();
    int gap;
    runSync(95, 0, 3);
    check("R6", "before loss locked", int'(locked), 1);
    check("R3", "before loss period", int'(activePeriod), 95);
    syncPer = 0;
    repeat (400) @(negedge clk);
    check("R6", "after loss locked", int'(locked), 0);
    check("R6", "after loss activePeriod", int'(activePeriod), PCFG);
    startGap(gap);
    startGap(gap);
    check("R6", "after loss spacing", gap, PCFG);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFreeRun();
    testSoftStart();
    testDisabled();
    testLockDiv1();
    testLockDivN(1, 52, "R2");
    testLockDivN(2, 34, "R2");
    testLockDivN(3, 26, "R2");
    testWindowEdge();
    testJump();
    testLoss();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule